// File: doc/BRIEF.md
# SDRAM Clock-Enable Power-State Tracker

This block sits on the device side of a single-data-rate mobile SDRAM model and follows the memory's power condition from the clock-enable pin. On every rising clock edge it takes the current clock-enable level, the level it had at the previous edge and the decoded command. It also takes three bank-status flags from the rest of the device: all banks idle, some bank active, and burst in progress. From these it decides whether the device stays in normal operation or moves into or out of precharge power-down, active power-down, self refresh, clock suspend or deep power-down.

Each transition produces a single-cycle, one-hot action code naming the entry or exit that happened. A combination that the device does not allow raises a single-cycle illegal flag and leaves the state as it was. Leaving deep power-down sets a sticky flag that tells the device's initialization logic to run the full power-up sequence again. After self refresh ends, a row-cycle window is counted, and any command other than NOP or DESELECT inside that window is flagged.

Top module: `cke_power_tracker`

## Requirements
- R1: While reset is asserted and after it, until the first accepted edge, the state is normal (code 0), the action code, illegal flag and reinit flag are 0, and the previous clock-enable level is taken as high.
- R2: In power-down, self refresh, clock suspend or deep power-down (codes 1..5), an edge where clock-enable is low and was low at the previous edge keeps the state, with no action and no illegal flag, whatever the command.
- R3: From precharge power-down (1), active power-down (2), self refresh (3) or deep power-down (5), clock-enable rising with command NOP (0) or DESELECT (1) returns to normal. The action bit is 5 for either power-down, 6 for self refresh and 8 for deep power-down. Clock-enable rising with any other command raises illegal and keeps the state. After such a refusal, clock-enable held high is illegal again, and clock-enable held low keeps the state quietly.
- R4: From clock suspend (4), clock-enable rising returns to normal (the burst resumes) with action bit 7, whatever the command.
- R5: From normal, clock-enable falling with NOP or DESELECT enters precharge power-down (action bit 0) if the banks-idle flag is set, or active power-down (action bit 1) if the banks-active flag is set. If neither flag is set, it raises illegal.
- R6: From normal, clock-enable falling with AUTO REFRESH (2) and banks idle enters self refresh (action bit 2). Without banks idle it raises illegal.
- R7: From normal, clock-enable falling while the burst flag is set enters clock suspend (action bit 3). This takes priority over the command.
- R8: From normal, clock-enable falling with the deep power-down command (5) and banks idle enters deep power-down (action bit 4).
- R9: Leaving deep power-down sets the reinit output. It stays set on every later edge until an edge where init-done is high, after which it reads 0.
- R10: For the TRC edges that follow a self-refresh exit, a command other than NOP or DESELECT in normal state raises illegal and causes no transition. The edge after that window is unrestricted.
- R11: In normal state, an edge where the previous clock-enable was low is illegal. So is clock-enable falling with READ (3), WRITE (4) or codes 6/7 without a burst. An edge with clock-enable high at both edges outside the window is legal and silent. An illegal edge never changes the state.
- R12: The state output, the action code and the illegal flag all reflect the edge just taken, one register stage after it. At most one action bit is set, and any set bit clears on the next edge unless a new transition occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchronizer |
| cke_i | input | 1 | Clock-enable level at this edge |
| cmd_i | input | 3 | Decoded command: 0 NOP, 1 DESELECT, 2 AUTO REFRESH, 3 READ, 4 WRITE, 5 deep power-down, 6/7 other |
| banks_idle_i | input | 1 | All banks are precharged |
| banks_active_i | input | 1 | At least one bank is open |
| burst_i | input | 1 | A read or write burst is in progress |
| init_done_i | input | 1 | Power-up initialization has finished |
| pstate_o | output | 3 | Power state: 0 normal, 1 precharge PD, 2 active PD, 3 self refresh, 4 clock suspend, 5 deep PD |
| action_o | output | 9 | One-hot transition code, one cycle per transition |
| illegal_o | output | 1 | Illegal sequence at the last edge |
| reinit_o | output | 1 | Full re-initialization required |

## Verification
The properties assume that the banks-idle and banks-active flags are never both high, that the command bus carries one of the eight codes on every edge, and that the burst flag goes high only with a bank open. Every vector in the bench table and every directed step drives exactly one of the two bank flags, or neither when the illegal case is the target. Burst is raised only together with banks active. The checker keeps its own copy of the previous clock-enable level, reset high like the design's, so that exit and stay properties depend only on the pins.

// File: rtl/cke_pwr_pkg.sv
package cke_pwr_pkg;

  typedef enum logic [2:0] {
    PS_NORMAL   = 3'd0,
    PS_PRE_PD   = 3'd1,
    PS_ACT_PD   = 3'd2,
    PS_SELF_REF = 3'd3,
    PS_CLK_SUSP = 3'd4,
    PS_DEEP_PD  = 3'd5
  } pstate_e;

  localparam int CMD_W = 3;
  localparam logic [CMD_W-1:0] CMD_NOP   = 3'd0;
  localparam logic [CMD_W-1:0] CMD_DESEL = 3'd1;
  localparam logic [CMD_W-1:0] CMD_AREF  = 3'd2;
  localparam logic [CMD_W-1:0] CMD_READ  = 3'd3;
  localparam logic [CMD_W-1:0] CMD_WRITE = 3'd4;
  localparam logic [CMD_W-1:0] CMD_DEEP  = 3'd5;

  localparam int ACT_W        = 9;
  localparam int ACT_ENT_PRE  = 0;
  localparam int ACT_ENT_ACT  = 1;
  localparam int ACT_ENT_SELF = 2;
  localparam int ACT_ENT_SUSP = 3;
  localparam int ACT_ENT_DEEP = 4;
  localparam int ACT_EXIT_PD  = 5;
  localparam int ACT_EXIT_SR  = 6;
  localparam int ACT_EXIT_SUS = 7;
  localparam int ACT_EXIT_DP  = 8;

endpackage

// File: rtl/cke_transition_decode.sv
module cke_transition_decode
  import cke_pwr_pkg::*;
(
  input  pstate_e               state_i,
  input  logic                  cke_prev_i,
  input  logic                  cke_i,
  input  logic [CMD_W-1:0]      cmd_i,
  input  logic                  banks_idle_i,
  input  logic                  banks_active_i,
  input  logic                  burst_i,
  input  logic                  win_busy_i,
  output pstate_e               state_nxt_o,
  output logic [ACT_W-1:0]      action_nxt_o,
  output logic                  illegal_nxt_o,
  output logic                  win_load_o,
  output logic                  reinit_set_o
);

  logic quiet_cmd;

  assign quiet_cmd = (cmd_i == CMD_NOP) || (cmd_i == CMD_DESEL);

  always_comb begin
    state_nxt_o   = state_i;
    action_nxt_o  = '0;
    illegal_nxt_o = 1'b0;
    win_load_o    = 1'b0;
    reinit_set_o  = 1'b0;
    unique case (state_i)
      PS_NORMAL: begin
        if (!cke_prev_i) begin
          illegal_nxt_o = 1'b1;
        end else if (win_busy_i && !quiet_cmd) begin
          illegal_nxt_o = 1'b1;
        end else if (!cke_i) begin
          if (burst_i) begin
            state_nxt_o                = PS_CLK_SUSP;
            action_nxt_o[ACT_ENT_SUSP] = 1'b1;
          end else if (quiet_cmd) begin
            if (banks_idle_i) begin
              state_nxt_o               = PS_PRE_PD;
              action_nxt_o[ACT_ENT_PRE] = 1'b1;
            end else if (banks_active_i) begin
              state_nxt_o               = PS_ACT_PD;
              action_nxt_o[ACT_ENT_ACT] = 1'b1;
            end else begin
              illegal_nxt_o = 1'b1;
            end
          end else if ((cmd_i == CMD_AREF) && banks_idle_i) begin
            state_nxt_o                = PS_SELF_REF;
            action_nxt_o[ACT_ENT_SELF] = 1'b1;
          end else if ((cmd_i == CMD_DEEP) && banks_idle_i) begin
            state_nxt_o                = PS_DEEP_PD;
            action_nxt_o[ACT_ENT_DEEP] = 1'b1;
          end else begin
            illegal_nxt_o = 1'b1;
          end
        end
      end
      PS_PRE_PD, PS_ACT_PD, PS_SELF_REF, PS_DEEP_PD: begin
        if (cke_i) begin
          if (!cke_prev_i && quiet_cmd) begin
            state_nxt_o = PS_NORMAL;
            if (state_i == PS_SELF_REF) begin
              action_nxt_o[ACT_EXIT_SR] = 1'b1;
              win_load_o                = 1'b1;
            end else if (state_i == PS_DEEP_PD) begin
              action_nxt_o[ACT_EXIT_DP] = 1'b1;
              reinit_set_o              = 1'b1;
            end else begin
              action_nxt_o[ACT_EXIT_PD] = 1'b1;
            end
          end else begin
            illegal_nxt_o = 1'b1;
          end
        end
      end
      PS_CLK_SUSP: begin
        if (cke_i) begin
          if (!cke_prev_i) begin
            state_nxt_o                = PS_NORMAL;
            action_nxt_o[ACT_EXIT_SUS] = 1'b1;
          end else begin
            illegal_nxt_o = 1'b1;
          end
        end
      end
      default: begin
        state_nxt_o   = PS_NORMAL;
        illegal_nxt_o = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/cke_trc_window.sv
module cke_trc_window #(
  parameter int TRC = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic busy_o
);

  localparam int CNT_W = (TRC < 1) ? 1 : $clog2(TRC + 1);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(TRC);

  generate
    if (TRC == 0) begin : g_no_window
      assign busy_o = 1'b0;
    end else begin : g_window
      logic [CNT_W-1:0] cnt_q;
      logic [CNT_W-1:0] cnt_d;
      logic             cnt_en;

      assign busy_o = (cnt_q != '0);
      assign cnt_en = load_i || busy_o;

      always_comb begin
        if (load_i) cnt_d = LOAD_VAL;
        else        cnt_d = cnt_q - 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (cnt_en) cnt_q <= cnt_d;
      end
    end
  endgenerate

endmodule

// File: rtl/cke_reinit_hold.sv
module cke_reinit_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clear_i,
  output logic flag_o
);

  logic flag_d;
  logic flag_en;

  assign flag_en = set_i || clear_i;
  assign flag_d  = set_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_o <= 1'b0;
    else if (flag_en) flag_o <= flag_d;
  end

endmodule

// File: rtl/cke_power_tracker.sv
module cke_power_tracker
  import cke_pwr_pkg::*;
#(
  parameter int TRC = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cke_i,
  input  logic [CMD_W-1:0]      cmd_i,
  input  logic                  banks_idle_i,
  input  logic                  banks_active_i,
  input  logic                  burst_i,
  input  logic                  init_done_i,
  output logic [2:0]            pstate_o,
  output logic [ACT_W-1:0]      action_o,
  output logic                  illegal_o,
  output logic                  reinit_o
);

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  pstate_e          state_q;
  pstate_e          state_d;
  logic             cke_prev_q;
  logic [ACT_W-1:0] action_d;
  logic [ACT_W-1:0] action_q;
  logic             illegal_d;
  logic             illegal_q;
  logic             win_busy;
  logic             win_load;
  logic             reinit_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  cke_transition_decode u_decode (
    .state_i        (state_q),
    .cke_prev_i     (cke_prev_q),
    .cke_i          (cke_i),
    .cmd_i          (cmd_i),
    .banks_idle_i   (banks_idle_i),
    .banks_active_i (banks_active_i),
    .burst_i        (burst_i),
    .win_busy_i     (win_busy),
    .state_nxt_o    (state_d),
    .action_nxt_o   (action_d),
    .illegal_nxt_o  (illegal_d),
    .win_load_o     (win_load),
    .reinit_set_o   (reinit_set)
  );

  cke_trc_window #(.TRC(TRC)) u_window (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .load_i (win_load),
    .busy_o (win_busy)
  );

  cke_reinit_hold u_reinit (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .set_i   (reinit_set),
    .clear_i (init_done_i),
    .flag_o  (reinit_o)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q    <= PS_NORMAL;
      cke_prev_q <= 1'b1;
      action_q   <= '0;
      illegal_q  <= 1'b0;
    end else begin
      state_q    <= state_d;
      cke_prev_q <= cke_i;
      action_q   <= action_d;
      illegal_q  <= illegal_d;
    end
  end

  assign pstate_o  = state_q;
  assign action_o  = action_q;
  assign illegal_o = illegal_q;

endmodule

// File: rtl/cke_power_tracker_chk.sv
module cke_power_tracker_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cke_i,
  input logic [2:0] cmd_i,
  input logic       burst_i,
  input logic       init_done_i,
  input logic [2:0] pstate_o,
  input logic [8:0] action_o,
  input logic       illegal_o,
  input logic       reinit_o
);

  logic cke_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cke_q <= 1'b1;
    else        cke_q <= cke_i;
  end

  assert_action_onehot_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(action_o));

  assert_action_moves_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (action_o != 9'd0) |-> (pstate_o != $past(pstate_o)));

  assert_illegal_keeps_state_R11: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> $stable(pstate_o));

  assert_low_low_stays_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_q && !cke_i && pstate_o != 3'd0)
      |=> ($stable(pstate_o) && action_o == 9'd0 && !illegal_o));

  assert_suspend_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pstate_o == 3'd4 && !cke_q && cke_i) |=> (pstate_o == 3'd0));

  assert_suspend_needs_burst_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pstate_o == 3'd4 && $past(pstate_o) != 3'd4) |-> $past(burst_i));

  assert_deep_exit_reinit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pstate_o == 3'd5 && !cke_q && cke_i && (cmd_i == 3'd0 || cmd_i == 3'd1))
      |=> reinit_o);

  assert_reinit_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reinit_o && !init_done_i) |=> reinit_o);

endmodule

bind cke_power_tracker cke_power_tracker_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cke_i       (cke_i),
  .cmd_i       (cmd_i),
  .burst_i     (burst_i),
  .init_done_i (init_done_i),
  .pstate_o    (pstate_o),
  .action_o    (action_o),
  .illegal_o   (illegal_o),
  .reinit_o    (reinit_o)
);

// File: tb/cke_power_tracker_test.sv
module cke_power_tracker_test;

  localparam int TRC = 10;
  localparam int NV  = 25;
  localparam int VW  = 22;

  // fields: cke, cmd[3], idle, active, burst, done, state[3], action[9], illegal, reinit
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b1, 3'd0, 4'b1000, 3'd0, 9'h000, 1'b0, 1'b0},  // R11 quiet high-high
    {1'b0, 3'd0, 4'b1000, 3'd1, 9'h001, 1'b0, 1'b0},  // R5 precharge PD
    {1'b0, 3'd3, 4'b1000, 3'd1, 9'h000, 1'b0, 1'b0},  // R2 stay
    {1'b1, 3'd3, 4'b1000, 3'd1, 9'h000, 1'b1, 1'b0},  // R3 refused exit
    {1'b0, 3'd0, 4'b1000, 3'd1, 9'h000, 1'b0, 1'b0},  // R3 drop cke, quiet
    {1'b1, 3'd1, 4'b1000, 3'd0, 9'h020, 1'b0, 1'b0},  // R3 exit PD
    {1'b0, 3'd0, 4'b0100, 3'd2, 9'h002, 1'b0, 1'b0},  // R5 active PD
    {1'b1, 3'd0, 4'b0100, 3'd0, 9'h020, 1'b0, 1'b0},  // R3 exit PD
    {1'b1, 3'd3, 4'b0110, 3'd0, 9'h000, 1'b0, 1'b0},  // R12 action cleared
    {1'b0, 3'd3, 4'b0110, 3'd4, 9'h008, 1'b0, 1'b0},  // R7 clock suspend
    {1'b0, 3'd2, 4'b0110, 3'd4, 9'h000, 1'b0, 1'b0},  // R2 stay
    {1'b1, 3'd4, 4'b0110, 3'd0, 9'h080, 1'b0, 1'b0},  // R4 resume burst
    {1'b0, 3'd4, 4'b0100, 3'd0, 9'h000, 1'b1, 1'b0},  // R11 write no burst
    {1'b1, 3'd0, 4'b0100, 3'd0, 9'h000, 1'b1, 1'b0},  // R11 prev low in normal
    {1'b0, 3'd2, 4'b0100, 3'd0, 9'h000, 1'b1, 1'b0},  // R6 refresh not idle
    {1'b1, 3'd0, 4'b0100, 3'd0, 9'h000, 1'b1, 1'b0},  // R11 prev low in normal
    {1'b0, 3'd0, 4'b0000, 3'd0, 9'h000, 1'b1, 1'b0},  // R5 no bank flag
    {1'b1, 3'd0, 4'b1000, 3'd0, 9'h000, 1'b1, 1'b0},  // R11 prev low in normal
    {1'b0, 3'd5, 4'b1000, 3'd5, 9'h010, 1'b0, 1'b0},  // R8 deep PD
    {1'b0, 3'd3, 4'b1000, 3'd5, 9'h000, 1'b0, 1'b0},  // R2 stay
    {1'b1, 3'd0, 4'b1000, 3'd0, 9'h100, 1'b0, 1'b1},  // R9 deep exit
    {1'b1, 3'd0, 4'b1000, 3'd0, 9'h000, 1'b0, 1'b1},  // R9 held
    {1'b1, 3'd0, 4'b1001, 3'd0, 9'h000, 1'b0, 1'b0},  // R9 cleared
    {1'b0, 3'd2, 4'b1000, 3'd3, 9'h004, 1'b0, 1'b0},  // R6 self refresh
    {1'b1, 3'd0, 4'b1000, 3'd0, 9'h040, 1'b0, 1'b0}   // R3 self refresh exit
  };

  localparam int VREQ [NV] = '{11, 5, 2, 3, 3, 3, 5, 3, 12, 7, 2, 4, 11, 11, 6, 11, 5, 11, 8, 2, 9, 9, 9, 6, 3};

  logic       clk;
  logic       rst_n;
  logic       cke_i;
  logic [2:0] cmd_i;
  logic       banks_idle_i;
  logic       banks_active_i;
  logic       burst_i;
  logic       init_done_i;
  logic [2:0] pstate_o;
  logic [8:0] action_o;
  logic       illegal_o;
  logic       reinit_o;

  int n_checks;
  int n_fails;
  bit finished;

  cke_power_tracker #(.TRC(TRC)) uut (
    .clk            (clk),
    .rst_n          (rst_n),
    .cke_i          (cke_i),
    .cmd_i          (cmd_i),
    .banks_idle_i   (banks_idle_i),
    .banks_active_i (banks_active_i),
    .burst_i        (burst_i),
    .init_done_i    (init_done_i),
    .pstate_o       (pstate_o),
    .action_o       (action_o),
    .illegal_o      (illegal_o),
    .reinit_o       (reinit_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic drive(input logic cke, input logic [2:0] cmd, input logic [3:0] flags);
    cke_i          = cke;
    cmd_i          = cmd;
    banks_idle_i   = flags[3];
    banks_active_i = flags[2];
    burst_i        = flags[1];
    init_done_i    = flags[0];
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input int req, input string what,
                       input logic [2:0] st, input logic [8:0] act,
                       input logic ill, input logic ri);
    n_checks++;
    if (pstate_o !== st || action_o !== act || illegal_o !== ill || reinit_o !== ri) begin
      n_fails++;
      $display("FAIL R%0d %s: actual st=%0d act=%03h ill=%0b ri=%0b expected st=%0d act=%03h ill=%0b ri=%0b",
               req, what, pstate_o, action_o, illegal_o, reinit_o, st, act, ill, ri);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    #200000;
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
    end
  end

  initial begin
    n_checks = 0;
    n_fails  = 0;
    finished = 1'b0;
    rst_n    = 1'b0;
    drive(1'b1, 3'd0, 4'b1000);
    repeat (2) step();
    check(1, "in reset", 3'd0, 9'h000, 1'b0, 1'b0);      // R1
    rst_n = 1'b1;
    repeat (3) step();
    check(1, "after release", 3'd0, 9'h000, 1'b0, 1'b0); // R1

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][21], VEC[i][20:18], VEC[i][17:14]);
      step();
      check(VREQ[i], $sformatf("vector %0d", i),
            VEC[i][13:11], VEC[i][10:2], VEC[i][1], VEC[i][0]);
    end

    // R10: the row-cycle window after the self-refresh exit of the last vector
    for (int k = 1; k < TRC; k++) begin
      drive(1'b1, 3'd0, 4'b1000);
      step();
      check(10, "window quiet edge", 3'd0, 9'h000, 1'b0, 1'b0);
    end
    drive(1'b1, 3'd3, 4'b1000);
    step();
    check(10, "read on last window edge", 3'd0, 9'h000, 1'b1, 1'b0);
    drive(1'b1, 3'd3, 4'b1000);
    step();
    check(10, "read after window", 3'd0, 9'h000, 1'b0, 1'b0);

    // R10: refresh re-entry attempted inside a fresh window is refused
    drive(1'b0, 3'd2, 4'b1000);
    step();
    check(6, "self refresh again", 3'd3, 9'h004, 1'b0, 1'b0);
    drive(1'b1, 3'd1, 4'b1000);
    step();
    check(3, "self refresh exit", 3'd0, 9'h040, 1'b0, 1'b0);
    drive(1'b0, 3'd2, 4'b1000);
    step();
    check(10, "refresh inside window", 3'd0, 9'h000, 1'b1, 1'b0);

    // R1: reset from a low-power state, prev clock-enable taken as high
    drive(1'b1, 3'd0, 4'b1000);
    repeat (TRC + 2) step();
    drive(1'b0, 3'd5, 4'b1000);
    step();
    check(8, "deep before reset", 3'd5, 9'h010, 1'b0, 1'b0);
    drive(1'b0, 3'd0, 4'b1000);
    #1 rst_n = 1'b0;
    #1;
    check(1, "async reset", 3'd0, 9'h000, 1'b0, 1'b0);
    step();
    rst_n = 1'b1;
    repeat (2) step();
    check(1, "held by synchronizer", 3'd0, 9'h000, 1'b0, 1'b0);
    step();
    step();
    check(1, "first edge sees prev high", 3'd1, 9'h000, 1'b0, 1'b0);

    finished = 1'b1;
    summary();
  end

endmodule